// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between an RV32I integer core and a data memory organised as 32-bit words. For every memory instruction the core hands over the raw instruction word together with the two source register values. The unit forms the effective address, decides the access width from the function field, and then does one of two things. If the access is naturally aligned, it drives a single-cycle memory request with the word address, the byte-lane enables and lane-aligned store data. If it is not aligned, it raises a misaligned exception for a load or for a store and suppresses the request.

Read data comes back from memory one cycle after a load request. The unit keeps the low address bits and the width and signedness of the load it issued. When the data arrives it takes the addressed byte or halfword out of the returned word and widens it to 32 bits. Instructions that are not loads or stores, and memory instructions with an unsupported function code, pass through without any memory activity and without a flag.

Top module: `lsu_top`

## Requirements
- R1: The effective address is rs1 plus a sign-extended 12-bit offset. Loads take the offset from inst[31:20]. Stores take it from inst[31:25] joined above inst[11:7]. mem_addr carries the effective address bits [31:2].
- R2: A store request has mem_we high. For a byte store (funct3 000), mem_be is 0001 shifted left by addr[1:0]. For a halfword store (001), mem_be is 0011 shifted left by 2*addr[1]. For a word store (010), mem_be is 1111.
- R3: For a byte store, the low byte of rs2 is copied into all four lanes of mem_wdata. For a halfword store, the low halfword is copied into both halves. A word store passes rs2 through unchanged.
- R4: A load request (opcode 0000011) has mem_we low and mem_be set to 1111. A load-type request is never followed by a data response from a store.
- R5: Exactly one cycle after a load request, ld_valid is high. ld_data then holds the lane of mem_rdata chosen by the address bits captured with the request. Function code 000 (byte), 001 (halfword) and 010 (word) sign-extend the selected value.
- R6: Function codes 100 (byte) and 101 (halfword) zero-extend the selected value.
- R7: No access whose address is a multiple of its size raises a misaligned flag. Byte accesses are never flagged.
- R8: A halfword load at an odd address, or a word load at an address that is not a multiple of 4, raises load_misaligned in the same cycle. It makes no request and produces no ld_valid in the next cycle.
- R9: A misaligned store (same address rule as R8) raises store_misaligned in the same cycle and makes no request.
- R10: No request and no flag are produced when op_valid is low, when the opcode is neither load nor store (0100011), or when the function code is unsupported (loads: 011, 110, 111; stores: 011 to 111).
- R11: During and right after reset, mem_req and ld_valid are low while op_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction presented this cycle |
| inst | input | 32 | Instruction word |
| rs1_val | input | 32 | Base register value |
| rs2_val | input | 32 | Store source register value |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, one cycle after a load request |
| load_misaligned | output | 1 | Misaligned load exception |
| store_misaligned | output | 1 | Misaligned store exception |
| ld_valid | output | 1 | Extended load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
The response path of one load and the request path of the next instruction share a cycle. The data returning for a load issued in cycle N is extracted in cycle N+1, while a new store or load issues in that same cycle. If it is a new load, that load overwrites the captured lane bits. The bench provokes both orders, load then store and load then load, with different lane offsets. It judges the first result against the first load's offset and width, and the second access against its own address, enables and data. This exposes any capture register that updates a cycle too early.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int XLEN     = 32;
    localparam int NLANES   = XLEN / 8;
    localparam int LO_W     = $clog2(NLANES);
    localparam int WADDR_W  = XLEN - LO_W;
    localparam int IMM_W    = 12;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_NONE = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic      is_load;
        logic      is_store;
        acc_size_e size;
        logic      uns;
    } mem_dec_t;

    function automatic mem_dec_t decode_mem(input logic [XLEN-1:0] ins);
        mem_dec_t   d;
        logic [2:0] f3;
        f3 = ins[14:12];
        d.is_load  = 1'b0;
        d.is_store = 1'b0;
        d.uns      = f3[2];
        d.size     = SZ_NONE;
        if (ins[6:0] == OPC_LOAD) begin
            d.is_load = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010)
                     || (f3 == 3'b100) || (f3 == 3'b101);
        end else if (ins[6:0] == OPC_STORE) begin
            d.is_store = (f3 == 3'b000) || (f3 == 3'b001) || (f3 == 3'b010);
        end
        if (d.is_load || d.is_store) begin
            d.size = acc_size_e'(f3[1:0]);
        end
        return d;
    endfunction

    function automatic logic [XLEN-1:0] offset_i(input logic [XLEN-1:0] ins);
        return {{(XLEN-IMM_W){ins[31]}}, ins[31:20]};
    endfunction

    function automatic logic [XLEN-1:0] offset_s(input logic [XLEN-1:0] ins);
        return {{(XLEN-IMM_W){ins[31]}}, ins[31:25], ins[11:7]};
    endfunction

    function automatic logic is_misaligned(input acc_size_e sz, input logic [LO_W-1:0] lo);
        logic r;
        case (sz)
            SZ_HALF: r = lo[0];
            SZ_WORD: r = (lo != '0);
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
    import lsu_pkg::*;
(
    input  logic            op_valid,
    input  logic [XLEN-1:0] inst,
    input  logic [XLEN-1:0] rs1_val,
    output logic [XLEN-1:0] eff_addr,
    output mem_dec_t        dec,
    output logic            misal
);

    logic [XLEN-1:0] offset;

    always_comb begin
        dec      = decode_mem(inst);
        offset   = dec.is_store ? offset_s(inst) : offset_i(inst);
        eff_addr = rs1_val + offset;
        misal    = op_valid && (dec.is_load || dec.is_store)
                && is_misaligned(dec.size, eff_addr[LO_W-1:0]);
    end

endmodule

// File: rtl/lsu_store_align.sv
module lsu_store_align
    import lsu_pkg::*;
(
    input  acc_size_e         size,
    input  logic [LO_W-1:0]   lo,
    input  logic [XLEN-1:0]   src,
    output logic [NLANES-1:0] be,
    output logic [XLEN-1:0]   wdata
);

    for (genvar l = 0; l < NLANES; l++) begin : g_lane
        localparam logic [LO_W-1:0] LANE = LO_W'(l);
        localparam int              HOFF = (l % 2) * 8;

        always_comb begin
            case (size)
                SZ_WORD: begin
                    be[l]          = 1'b1;
                    wdata[8*l +: 8] = src[8*l +: 8];
                end
                SZ_HALF: begin
                    be[l]          = (LANE[LO_W-1:1] == lo[LO_W-1:1]);
                    wdata[8*l +: 8] = src[HOFF +: 8];
                end
                SZ_BYTE: begin
                    be[l]          = (LANE == lo);
                    wdata[8*l +: 8] = src[7:0];
                end
                default: begin
                    be[l]          = 1'b0;
                    wdata[8*l +: 8] = src[8*l +: 8];
                end
            endcase
        end
    end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  acc_size_e       size,
    input  logic            uns,
    input  logic [LO_W-1:0] lo,
    input  logic [XLEN-1:0] rdata,
    output logic            ld_valid,
    output logic [XLEN-1:0] ld_data
);

    logic            pend_q;
    logic [LO_W-1:0] lo_q;
    acc_size_e       size_q;
    logic            uns_q;
    logic [XLEN-1:0] shifted;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            lo_q   <= '0;
            size_q <= SZ_NONE;
            uns_q  <= 1'b0;
        end else begin
            pend_q <= capture;
            if (capture) begin
                lo_q   <= lo;
                size_q <= size;
                uns_q  <= uns;
            end
        end
    end

    always_comb begin
        shifted = rdata >> (8 * int'(lo_q));
        case (size_q)
            SZ_BYTE: ld_data = {{(XLEN-8){~uns_q & shifted[7]}}, shifted[7:0]};
            SZ_HALF: ld_data = {{(XLEN-16){~uns_q & shifted[15]}}, shifted[15:0]};
            default: ld_data = rdata;
        endcase
    end

    assign ld_valid = pend_q;

endmodule

// File: rtl/lsu_top.sv
module lsu_top
    import lsu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic [XLEN-1:0]     inst,
    input  logic [XLEN-1:0]     rs1_val,
    input  logic [XLEN-1:0]     rs2_val,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WADDR_W-1:0]  mem_addr,
    output logic [NLANES-1:0]   mem_be,
    output logic [XLEN-1:0]     mem_wdata,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                load_misaligned,
    output logic                store_misaligned,
    output logic                ld_valid,
    output logic [XLEN-1:0]     ld_data
);

    logic [XLEN-1:0]   eff_addr;
    mem_dec_t          dec;
    logic              misal;
    logic              issue;
    logic [NLANES-1:0] st_be;

    lsu_agen u_agen (
        .op_valid (op_valid),
        .inst     (inst),
        .rs1_val  (rs1_val),
        .eff_addr (eff_addr),
        .dec      (dec),
        .misal    (misal)
    );

    lsu_store_align u_st (
        .size  (dec.size),
        .lo    (eff_addr[LO_W-1:0]),
        .src   (rs2_val),
        .be    (st_be),
        .wdata (mem_wdata)
    );

    assign issue            = op_valid && (dec.is_load || dec.is_store) && !misal;
    assign mem_req          = issue;
    assign mem_we           = issue && dec.is_store;
    assign mem_addr         = eff_addr[XLEN-1:LO_W];
    assign mem_be           = !issue ? '0 : (dec.is_store ? st_be : '1);
    assign load_misaligned  = misal && dec.is_load;
    assign store_misaligned = misal && dec.is_store;

    lsu_load_extract u_ld (
        .clk      (clk),
        .rst      (rst),
        .capture  (issue && dec.is_load),
        .size     (dec.size),
        .uns      (dec.uns),
        .lo       (eff_addr[LO_W-1:0]),
        .rdata    (mem_rdata),
        .ld_valid (ld_valid),
        .ld_data  (ld_data)
    );

endmodule

// File: rtl/lsu_checker.sv
module lsu_checker
    import lsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [XLEN-1:0]   inst,
    input logic              mem_req,
    input logic              mem_we,
    input logic [NLANES-1:0] mem_be,
    input logic              load_misaligned,
    input logic              store_misaligned,
    input logic              ld_valid
);

    logic [2:0] f3;
    assign f3 = inst[14:12];

    // R8
    ldmis_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        load_misaligned |-> !mem_req);

    // R8
    ldmis_nodata_chk: assert property (@(posedge clk) disable iff (rst)
        (load_misaligned && !mem_req) |=> !ld_valid);

    // R9
    stmis_noreq_chk: assert property (@(posedge clk) disable iff (rst)
        store_misaligned |-> !mem_req);

    // R5
    ld_resp_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |=> ld_valid);

    // R4
    ld_origin_chk: assert property (@(posedge clk) disable iff (rst)
        ld_valid |-> $past(mem_req && !mem_we));

    // R2
    sb_be_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && f3 == 3'b000) |-> $countones(mem_be) == 1);

    // R2
    sw_be_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && f3 == 3'b010) |-> mem_be == '1);

    // R10
    req_needs_op_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> op_valid);

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(load_misaligned && store_misaligned));

endmodule

bind lsu_top lsu_checker u_chk (
    .clk              (clk),
    .rst              (rst),
    .op_valid         (op_valid),
    .inst             (inst),
    .mem_req          (mem_req),
    .mem_we           (mem_we),
    .mem_be           (mem_be),
    .load_misaligned  (load_misaligned),
    .store_misaligned (store_misaligned),
    .ld_valid         (ld_valid)
);

// File: tb/lsu_top_tb.sv
module lsu_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [31:0] inst, rs1_val, rs2_val, mem_rdata;
    logic        mem_req, mem_we, load_misaligned, store_misaligned, ld_valid;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata, ld_data;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_top dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .inst(inst),
        .rs1_val(rs1_val), .rs2_val(rs2_val), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .load_misaligned(load_misaligned), .store_misaligned(store_misaligned),
        .ld_valid(ld_valid), .ld_data(ld_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] sx12(input logic [11:0] v);
        return {{20{v[11]}}, v};
    endfunction

    function automatic logic [31:0] mk_load(input logic [11:0] imm, input logic [2:0] f3);
        return {imm, 5'd1, f3, 5'd2, 7'b0000011};
    endfunction

    function automatic logic [31:0] mk_store(input logic [11:0] imm, input logic [2:0] f3);
        return {imm[11:5], 5'd3, 5'd1, f3, imm[4:0], 7'b0100011};
    endfunction

    function automatic bit ld_legal(input logic [2:0] f3);
        return f3 == 3'd0 || f3 == 3'd1 || f3 == 3'd2 || f3 == 3'd4 || f3 == 3'd5;
    endfunction

    function automatic bit mis(input logic [2:0] f3, input logic [1:0] lo);
        if (f3[1:0] == 2'd1) return lo[0];
        if (f3[1:0] == 2'd2) return lo != 2'd0;
        return 1'b0;
    endfunction

    function automatic logic [31:0] exp_ld(input logic [31:0] w, input logic [1:0] lo, input logic [2:0] f3);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*lo +: 8];
        h = lo[1] ? w[31:16] : w[15:0];
        case (f3)
            3'd0: return sx12({{4{b[7]}}, b});
            3'd1: return {{16{h[15]}}, h};
            3'd4: return {24'd0, b};
            3'd5: return {16'd0, h};
            default: return w;
        endcase
    endfunction

    function automatic logic [3:0] exp_be(input logic [2:0] f3, input logic [1:0] lo);
        if (f3 == 3'd0) return 4'b0001 << lo;
        if (f3 == 3'd1) return 4'b0011 << (2 * lo[1]);
        return 4'b1111;
    endfunction

    function automatic logic [31:0] exp_wd(input logic [2:0] f3, input logic [31:0] d);
        if (f3 == 3'd0) return {4{d[7:0]}};
        if (f3 == 3'd1) return {2{d[15:0]}};
        return d;
    endfunction

    // Issue one load; checks request cycle then response cycle.
    task automatic do_load(input logic [2:0] f3, input logic [31:0] ea, input logic [11:0] imm,
                           input logic [31:0] word);
        bit legal, m, er;
        legal = ld_legal(f3);
        m     = legal && mis(f3, ea[1:0]);
        er    = legal && !m;
        @(negedge clk);
        op_valid = 1'b1;
        inst     = mk_load(imm, f3);
        rs1_val  = ea - sx12(imm);
        rs2_val  = 32'hDEAD_BEEF;
        #2;
        chk(mem_req == er, legal ? "R7/R8 load req" : "R10 load req", {31'd0, mem_req}, {31'd0, er});
        chk(load_misaligned == m, "R8 load flag", {31'd0, load_misaligned}, {31'd0, m});
        chk(!store_misaligned, "R10 st flag on load", {31'd0, store_misaligned}, 32'd0);
        if (er) begin
            chk(mem_addr == ea[31:2], "R1 load addr", {2'd0, mem_addr}, {2'd0, ea[31:2]});
            chk(!mem_we && mem_be == 4'hF, "R4 load we/be", {27'd0, mem_we, mem_be}, 32'h0F);
        end
        @(negedge clk);
        op_valid  = 1'b0;
        mem_rdata = word;
        #2;
        chk(ld_valid == er, er ? "R5 ld_valid" : "R8 no response", {31'd0, ld_valid}, {31'd0, er});
        if (er)
            chk(ld_data == exp_ld(word, ea[1:0], f3), f3[2] ? "R6 ld_data" : "R5 ld_data",
                ld_data, exp_ld(word, ea[1:0], f3));
    endtask

    task automatic do_store(input logic [2:0] f3, input logic [31:0] ea, input logic [11:0] imm,
                            input logic [31:0] d);
        bit legal, m, er;
        legal = (f3 <= 3'd2);
        m     = legal && mis(f3, ea[1:0]);
        er    = legal && !m;
        @(negedge clk);
        op_valid = 1'b1;
        inst     = mk_store(imm, f3);
        rs1_val  = ea - sx12(imm);
        rs2_val  = d;
        #2;
        chk(mem_req == er, legal ? "R7/R9 store req" : "R10 store req", {31'd0, mem_req}, {31'd0, er});
        chk(store_misaligned == m, "R9 store flag", {31'd0, store_misaligned}, {31'd0, m});
        chk(!load_misaligned, "R10 ld flag on store", {31'd0, load_misaligned}, 32'd0);
        if (er) begin
            chk(mem_we, "R2 store we", {31'd0, mem_we}, 32'd1);
            chk(mem_addr == ea[31:2], "R1 store addr", {2'd0, mem_addr}, {2'd0, ea[31:2]});
            chk(mem_be == exp_be(f3, ea[1:0]), "R2 store be", {28'd0, mem_be}, {28'd0, exp_be(f3, ea[1:0])});
            chk(mem_wdata == exp_wd(f3, d), "R3 store wdata", mem_wdata, exp_wd(f3, d));
        end
        @(negedge clk);
        op_valid = 1'b0;
        #2;
        chk(!ld_valid, "R4 no response after store", {31'd0, ld_valid}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [11:0] imms [4];
        logic [31:0] bases [2];
        logic [31:0] ea, w;
        imms[0] = 12'h000; imms[1] = 12'h7FF; imms[2] = 12'h800; imms[3] = 12'h015;
        bases[0] = 32'h1000_0040; bases[1] = 32'hFFFF_FFF0;
        rst = 1'b1; op_valid = 1'b0; inst = 32'd0; rs1_val = 32'd0; rs2_val = 32'd0;
        mem_rdata = 32'd0;
        repeat (3) @(negedge clk);
        #2;
        chk(!mem_req && !ld_valid, "R11 reset state", {30'd0, mem_req, ld_valid}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk(!mem_req && !ld_valid, "R11 after reset", {30'd0, mem_req, ld_valid}, 32'd0);

        for (int f = 0; f < 8; f++)
            for (int lo = 0; lo < 4; lo++)
                for (int ii = 0; ii < 4; ii++)
                    for (int bi = 0; bi < 2; bi++) begin
                        ea = bases[bi] + 32'(lo);
                        w  = 32'h80F1_7E93 ^ (32'(f) << 5) ^ (32'(ii) << 22) ^ (32'(bi) << 15);
                        do_load(3'(f), ea, imms[ii], w);
                        do_store(3'(f), ea, imms[ii], w ^ 32'h5A5A_A5A5);
                    end

        // R10: non-memory opcode and op_valid low
        @(negedge clk);
        op_valid = 1'b1; inst = 32'h0010_8113; rs1_val = 32'h100;
        #2;
        chk(!mem_req && !load_misaligned && !store_misaligned, "R10 non-mem opcode",
            {29'd0, mem_req, load_misaligned, store_misaligned}, 32'd0);
        @(negedge clk);
        op_valid = 1'b0; inst = mk_load(12'h001, 3'd2); rs1_val = 32'h0;
        #2;
        chk(!mem_req && !load_misaligned, "R10 op_valid low",
            {30'd0, mem_req, load_misaligned}, 32'd0);

        // Overlap: load (lane 3, LB) then store in response cycle
        @(negedge clk);
        op_valid = 1'b1; inst = mk_load(12'h003, 3'd0); rs1_val = 32'h2000;
        @(negedge clk);
        inst = mk_store(12'h002, 3'd1); rs1_val = 32'h3000; rs2_val = 32'h1234_ABCD;
        mem_rdata = 32'h9C33_2211;
        #2;
        chk(ld_valid && ld_data == 32'hFFFF_FF9C, "R5 overlap load data", ld_data, 32'hFFFF_FF9C);
        chk(mem_req && mem_we && mem_be == 4'b1100 && mem_wdata == 32'hABCD_ABCD,
            "R3 overlap store", mem_wdata, 32'hABCD_ABCD);
        // Overlap: load LHU at lane 2 then LBU at lane 1 back to back
        @(negedge clk);
        inst = mk_load(12'h002, 3'd5); rs1_val = 32'h4000;
        #2;
        chk(!ld_valid, "R4 store gave no response", {31'd0, ld_valid}, 32'd0);
        @(negedge clk);
        inst = mk_load(12'h001, 3'd4); rs1_val = 32'h4000;
        mem_rdata = 32'h8765_4321;
        #2;
        chk(ld_valid && ld_data == 32'h0000_8765, "R6 back-to-back first", ld_data, 32'h0000_8765);
        @(negedge clk);
        op_valid = 1'b0; mem_rdata = 32'h11F0_2233;
        #2;
        chk(ld_valid && ld_data == 32'h0000_0022, "R6 back-to-back second", ld_data, 32'h0000_0022);
        @(negedge clk);
        #2;
        chk(!ld_valid, "R5 single response", {31'd0, ld_valid}, 32'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule